// File: doc/BRIEF.md
# Multi-Channel Pattern and State Trigger

This block watches four sampled logic channels and raises a one-cycle trigger pulse when a programmed logic condition is found. Each channel is qualified as high, low or don't-care, and the qualified terms are merged by one of four functions: AND, OR, NAND or NOR. The channels are assumed to be synchronous to `clk` already. Analog thresholds are handled elsewhere.

In pattern mode the merged result must hold a chosen polarity, true or false, for a programmed number of consecutive samples. The trigger then fires once, and it does not fire again until the condition has broken. In state mode the last channel does not take part in the pattern. It acts as a qualifying clock instead: the merged result of the other three channels is tested only on the sample where that channel shows the selected edge.

Top module: `lpat_trigger`

## Requirements
- R1: While `rst_n` is low, `trig_out` is low, and it stays low on the first cycle after reset is released.
- R2: The qualifier of channel i is `qual_cfg[2i+1:2i]`. Code 01 makes the channel's term equal to the channel. Code 10 makes the term the channel's inverse. Codes 00 and 11 are don't-care.
- R3: `comb_fn` selects the merge: 00 AND, 01 OR, 10 NAND, 11 NOR. A don't-care channel contributes 1 under AND and NAND and 0 under OR and NOR. With every channel don't-care, the result is therefore 1 for AND and NOR and 0 for OR and NAND.
- R4: In pattern mode (`state_mode`=0), a sample is met when the merged result equals `want_true`. `trig_out` is high on the cycle after the sample that ends a run of `dwell_len`+1 consecutive met samples.
- R5: With `dwell_len`=0, pattern mode fires after the first met sample of a run.
- R6: A non-met sample restarts the run count. At most one pulse is produced per run, so `trig_out` is never high on two consecutive cycles.
- R7: In state mode (`state_mode`=1), `trig_out` is high on the cycle after a sample in which `chan_in[3]` shows the selected edge compared with the previous sample. That same sample must also have a merged result of 1 over channels 0 to 2. The qualifier of channel 3 is ignored in this mode.
- R8: `edge_fall`=0 selects the rising edge (previous 0, current 1) of `chan_in[3]`. `edge_fall`=1 selects the falling edge.
- R9: The first sample after reset has no previous value and never counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in | input | 4 | Sampled logic channels, index 3 is the state-mode clock |
| qual_cfg | input | 8 | Two-bit qualifier per channel |
| comb_fn | input | 2 | Merge function select |
| state_mode | input | 1 | 0 pattern mode, 1 state mode |
| edge_fall | input | 1 | State-mode edge select, 1 = falling |
| want_true | input | 1 | Pattern-mode polarity: 1 waits for true, 0 waits for false |
| dwell_len | input | 16 | Pattern-mode run length threshold |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
All sixteen channel patterns are swept under each of the four merge functions, with mixed qualifiers and both polarities. This separates wrong qualifier decoding from a wrong function or a missing inversion. All-don't-care runs isolate the identity value each function assigns to masked channels. Runs of met samples are broken one sample short of the threshold and then completed, which tells an off-by-one in the run count from a failure to restart. State-mode sequences toggle channel 3 with the pattern both false and true on the edge sample, under both edge selections. They also start with channel 3 already high after reset, to show that the sample clock neither fires without a previous value nor reacts to its own qualifier.

// File: rtl/lpat_pkg.sv
// Shared encodings for the pattern/state trigger.
// Assumes two-bit qualifier codes and two-bit function codes as listed below.
package lpat_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NAND = 2'b10,
        FN_NOR  = 2'b11
    } comb_fn_t;

    localparam logic [1:0] QUAL_HIGH = 2'b01;
    localparam logic [1:0] QUAL_LOW  = 2'b10;

    // Neutral value a masked channel contributes under a given function.
    function automatic logic fn_identity(input comb_fn_t fn);
        return (fn == FN_AND) || (fn == FN_NAND);
    endfunction

    // True when the function inverts its reduced value.
    function automatic logic fn_inverts(input comb_fn_t fn);
        return (fn == FN_NAND) || (fn == FN_NOR);
    endfunction

endpackage

// File: rtl/lpat_combine.sv
// Qualifies each channel and merges the terms with the selected function.
// Purely combinational. In state mode the last channel is forced to the
// identity value, because it serves as the sample clock.
module lpat_combine
    import lpat_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]   chan,
    input  logic [2*NUM_CH-1:0] qual_cfg,
    input  logic [1:0]          comb_fn,
    input  logic                state_mode,
    output logic                result
);

    comb_fn_t               fn;
    logic                   ident;
    logic [NUM_CH-1:0]      term;
    logic                   reduced;

    // Decode the function select and its neutral element.
    always_comb begin
        fn    = comb_fn_t'(comb_fn);
        ident = fn_identity(fn);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_term
        logic [1:0] q;
        logic       masked;
        assign q = qual_cfg[2*i +: 2];
        if (i == NUM_CH - 1) begin : g_clk_ch
            assign masked = state_mode;
        end else begin : g_data_ch
            assign masked = 1'b0;
        end
        // Per-channel term: follow, invert or substitute the identity.
        always_comb begin
            if (masked)
                term[i] = ident;
            else if (q == QUAL_HIGH)
                term[i] = chan[i];
            else if (q == QUAL_LOW)
                term[i] = ~chan[i];
            else
                term[i] = ident;
        end
    end

    // Reduce the terms and apply the optional inversion.
    always_comb begin
        reduced = ident ? (&term) : (|term);
        result  = fn_inverts(fn) ? ~reduced : reduced;
    end

endmodule

// File: rtl/lpat_dwell.sv
// Counts consecutive met samples and flags the sample that completes a run
// of dwell_len+1. Fires once per run. Assumes met is evaluated every cycle.
module lpat_dwell #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             met,
    input  logic [CNT_W-1:0] dwell_len,
    output logic             hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_cnt;
    logic             done;

    // Hit when the run has already seen dwell_len met samples before this one.
    always_comb begin
        hit = enable && met && !done && (run_cnt == dwell_len);
    end

    // Advance the run count, restarting on a broken run or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !met) begin
            run_cnt <= '0;
            done    <= 1'b0;
        end else begin
            if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + 1'b1;
            if (hit)
                done <= 1'b1;
        end
    end

endmodule

// File: rtl/lpat_edge.sv
// Detects the selected edge of one sampled signal by comparing it with
// the previous sample. No edge is reported until a previous sample exists.
module lpat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic fall_sel,
    output logic edge_hit
);

    logic prev;
    logic primed;

    // Compare the current and previous samples in the selected direction.
    always_comb begin
        if (fall_sel)
            edge_hit = primed && prev && !sig;
        else
            edge_hit = primed && !prev && sig;
    end

    // Keep the last sample and note that one has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= 1'b0;
            primed <= 1'b0;
        end else begin
            prev   <= sig;
            primed <= 1'b1;
        end
    end

endmodule

// File: rtl/lpat_trigger.sv
// Top of the pattern/state trigger. Merges the qualified channels, then
// either waits on a run of matching samples (pattern mode) or tests the
// merged result on an edge of the last channel (state mode). The output
// is registered, so a pulse appears one cycle after its deciding sample.
module lpat_trigger
    import lpat_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   chan_in,
    input  logic [2*NUM_CH-1:0] qual_cfg,
    input  logic [1:0]          comb_fn,
    input  logic                state_mode,
    input  logic                edge_fall,
    input  logic                want_true,
    input  logic [CNT_W-1:0]    dwell_len,
    output logic                trig_out
);

    logic comb_result;
    logic dwell_met;
    logic dwell_hit;
    logic clk_edge;
    logic fire_now;

    lpat_combine #(.NUM_CH(NUM_CH)) u_combine (
        .chan       (chan_in),
        .qual_cfg   (qual_cfg),
        .comb_fn    (comb_fn),
        .state_mode (state_mode),
        .result     (comb_result)
    );

    // A sample is met when the merged value has the wanted polarity.
    always_comb begin
        dwell_met = (comb_result == want_true);
    end

    lpat_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!state_mode),
        .met       (dwell_met),
        .dwell_len (dwell_len),
        .hit       (dwell_hit)
    );

    lpat_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (chan_in[NUM_CH-1]),
        .fall_sel (edge_fall),
        .edge_hit (clk_edge)
    );

    // Pick the firing condition of the active mode.
    always_comb begin
        fire_now = state_mode ? (clk_edge && comb_result) : dwell_hit;
    end

    // Register the trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_out <= 1'b0;
        else
            trig_out <= fire_now;
    end

endmodule

// File: rtl/lpat_trigger_chk.sv
// Temporal checks for lpat_trigger, bound to every instance.
module lpat_trigger_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_in,
    input logic              state_mode,
    input logic              edge_fall,
    input logic              trig_out,
    input logic              comb_result,
    input logic              dwell_met
);

    // R1: no pulse on the first cycle out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !trig_out);

    // R6: pulses are never back to back.
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R4: a pattern-mode pulse follows a met sample.
    a_r4_pattern_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && !$past(state_mode)) |-> $past(dwell_met));

    // R7: a state-mode pulse follows a sample whose merged result was true.
    a_r7_state_needs_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(state_mode)) |-> $past(comb_result));

    // R8: a rising-edge state-mode pulse follows a 0 then 1 on the clock channel.
    a_r8_rising_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(state_mode) && !$past(edge_fall))
            |-> ($past(chan_in[NUM_CH-1]) && !$past(chan_in[NUM_CH-1], 2)));

    // R8: a falling-edge state-mode pulse follows a 1 then 0 on the clock channel.
    a_r8_falling_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(state_mode) && $past(edge_fall))
            |-> (!$past(chan_in[NUM_CH-1]) && $past(chan_in[NUM_CH-1], 2)));

endmodule

bind lpat_trigger lpat_trigger_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_in     (chan_in),
    .state_mode  (state_mode),
    .edge_fall   (edge_fall),
    .trig_out    (trig_out),
    .comb_result (comb_result),
    .dwell_met   (dwell_met)
);

// File: tb/lpat_trigger_test.sv
// Scoreboard bench: the driver computes the expected pulse of each sample and
// queues it; the monitor compares it with trig_out one cycle later.
module lpat_trigger_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  chan_in = '0;
    logic [7:0]  qual_cfg = '0;
    logic [1:0]  comb_fn = '0;
    logic        state_mode = 1'b0;
    logic        edge_fall = 1'b0;
    logic        want_true = 1'b1;
    logic [15:0] dwell_len = '0;
    logic        trig_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];

    // Reference state.
    int m_cnt = 0;
    bit m_fired = 0;
    bit m_prev = 0;
    bit m_primed = 0;

    // Requested settings, applied at the next driven sample.
    logic [7:0]  c_qual = '0;
    logic [1:0]  c_fn = '0;
    bit          c_state = 0;
    bit          c_fall = 0;
    bit          c_want = 1;
    int          c_len = 0;

    always #10 clk = ~clk;

    lpat_trigger uut (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .qual_cfg(qual_cfg),
        .comb_fn(comb_fn), .state_mode(state_mode), .edge_fall(edge_fall),
        .want_true(want_true), .dwell_len(dwell_len), .trig_out(trig_out)
    );

    function automatic bit ref_merge(input logic [3:0] ch);
        bit and_like;
        bit acc;
        and_like = (c_fn == 2'b00) || (c_fn == 2'b10);
        acc = and_like;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] q;
            bit t;
            q = c_qual[2*i +: 2];
            if (c_state && i == 3) continue;
            if (q == 2'b01) t = ch[i];
            else if (q == 2'b10) t = !ch[i];
            else continue;
            acc = and_like ? (acc & t) : (acc | t);
        end
        return (c_fn[1]) ? !acc : acc;
    endfunction

    task automatic drive(input logic [3:0] ch, input string tag);
        bit e;
        bit m;
        bit edge_seen;
        @(negedge clk);
        chan_in = ch; qual_cfg = c_qual; comb_fn = c_fn; state_mode = c_state;
        edge_fall = c_fall; want_true = c_want; dwell_len = 16'(c_len);
        m = ref_merge(ch);
        edge_seen = m_primed && (c_fall ? (m_prev && !ch[3]) : (!m_prev && ch[3]));
        if (c_state) begin
            m_cnt = 0; m_fired = 0;
            e = edge_seen && m;
        end else if (m != c_want) begin
            m_cnt = 0; m_fired = 0; e = 0;
        end else begin
            e = !m_fired && (m_cnt == c_len);
            if (e) m_fired = 1;
            if (m_cnt < 65535) m_cnt++;
        end
        m_prev = ch[3];
        m_primed = 1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each queued expectation after the edge that produces it.
    always @(posedge clk) begin
        #5;
        if (rst_n && exp_q.size() > 0) begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (trig_out !== e) begin
                errors++;
                $display("FAIL %s trig_out=%b expected=%b", t, trig_out, e);
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog trig_out=%b expected=end of run", trig_out);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet during reset.
        repeat (3) @(negedge clk);
        checks++;
        if (trig_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 trig_out=%b expected=0 in reset", trig_out);
        end

        // R9: state mode, clock channel already high on the first sample.
        c_state = 1; c_fall = 0; c_qual = 8'b01_00_00_00; c_fn = 2'b00;
        qual_cfg = c_qual; state_mode = 1; chan_in = 4'b1000;
        @(negedge clk); rst_n = 1'b1;
        drive(4'b1000, "R9");
        drive(4'b1000, "R1");
        drive(4'b0000, "R8");
        drive(4'b1000, "R7");   // rising edge, all data don't-care: fire
        drive(4'b1000, "R7");

        // R8: falling edge selection.
        c_fall = 1;
        drive(4'b0000, "R8");
        drive(4'b1000, "R8");
        drive(4'b0000, "R8");

        // R7: pattern gating on the edge sample; channel 3 qualifier ignored.
        c_fall = 0; c_qual = 8'b10_00_00_01;
        drive(4'b0000, "R7");
        drive(4'b1000, "R7");   // edge but ch0 low: no fire
        drive(4'b0001, "R7");
        drive(4'b1001, "R7");   // edge with ch0 high: fire
        drive(4'b0001, "R7");

        // R2/R3: sweep functions and patterns, both polarities, zero length.
        c_state = 0; c_len = 0;
        for (int pol = 0; pol < 2; pol++) begin
            c_want = pol[0];
            for (int f = 0; f < 4; f++) begin
                c_fn = 2'(f);
                c_qual = 8'b01_10_11_01;
                for (int p = 0; p < 16; p++) drive(4'(p), "R3");
                c_qual = 8'b10_01_00_10;
                for (int p = 15; p >= 0; p--) drive(4'(p), "R2");
            end
        end

        // R3: all don't-care gives the identity-based constant.
        c_want = 1; c_qual = 8'h00;
        for (int f = 0; f < 4; f++) begin
            c_fn = 2'(f);
            c_want = 0; drive(4'b0101, "R3");
            c_want = 1; drive(4'b1010, "R3");
            drive(4'b1111, "R3");
        end

        // R4/R6: run of 4 needed, broken one short, then completed and held.
        c_fn = 2'b00; c_qual = 8'h55; c_want = 1; c_len = 3;
        drive(4'b0000, "R4");
        for (int k = 0; k < 3; k++) drive(4'b1111, "R4");
        drive(4'b1110, "R6");
        for (int k = 0; k < 7; k++) drive(4'b1111, "R4");
        drive(4'b0000, "R6");
        for (int k = 0; k < 5; k++) drive(4'b1111, "R6");

        // R4: waiting for false, length 2, under OR.
        c_fn = 2'b01; c_want = 0; c_len = 2;
        drive(4'b0001, "R4");
        for (int k = 0; k < 4; k++) drive(4'b0000, "R4");

        // R5: zero length fires on the first met sample.
        c_fn = 2'b11; c_want = 1; c_len = 0;
        drive(4'b0100, "R5");
        drive(4'b0000, "R5");
        drive(4'b0000, "R5");
        drive(4'b0010, "R5");
        drive(4'b0000, "R5");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule